// File: doc/BRIEF.md
# Receive Message Buffer Tracker

This block does the accounting for the receive message store of a CAN-style bus controller. The protocol engine tells it when a frame begins, when each data byte is written into the store, and when the frame completes, together with that frame's length in bytes. The block decides at frame completion whether the whole message fits in the space left. A message that fits is kept and counted. A message that does not fit is thrown away and leaves no bytes behind. The outcome is reported as a message count, a buffer-holds-data status, a sticky overrun flag and a per-frame miss flag.

The host acts on the store with single-cycle command pulses on a 5-bit command word. Bit 2 releases the oldest stored message. Bit 3 clears the overrun flag. Because the block keeps the length of every stored message in arrival order, a release frees exactly the bytes of the oldest message. The reset-mode input aborts any frame in progress. Stored messages stay where they are.

Top module: `rx_msg_tracker`

## Requirements
- R1: The message count rises by one the cycle after each message is stored and falls by one the cycle after each accepted release command (command bit 2). When both happen in the same cycle, the count does not change.
- R2: The buffer status output is 1 whenever the count is at least one, and 0 when the count is zero.
- R3: At frame end, a message is dropped if the bytes already held plus the frame length exceed the capacity (64 bytes by default). When a message is dropped, the count does not change, the bytes it partly wrote are freed, and both the overrun flag and the miss flag are set the cycle after.
- R4: The overrun flag stays at 1 until a clear command (command bit 3) arrives. If a drop and a clear happen in the same cycle, the flag stays at 1.
- R5: The miss flag stays 0 after a message is stored. Once set, it stays set until the next accepted frame start.
- R6: While reset mode is 1, the frame in progress is aborted and its partly written bytes are freed. The miss flag is cleared. Frame start, byte and end strobes are ignored. Stored messages and the count are not affected.
- R7: A release command has no effect when the count is zero. Messages are released in the order they arrived, and each release frees exactly the stored length of the oldest message.
- R8: The used-bytes output equals the sum of the lengths of the stored messages plus the bytes written so far by the frame in progress. Byte writes that would take this sum past the capacity are not counted.
- R9: Commands act only while the command write strobe is 1. Command bits 0, 1 and 4 have no effect.
- R10: After reset, the count, used bytes, buffer status, overrun flag and miss flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reset_mode_i | input | 1 | Controller reset mode; aborts the frame in progress |
| frame_start_i | input | 1 | Pulse: a new frame begins |
| byte_wr_i | input | 1 | Pulse: one byte of the current frame is written to the store |
| frame_end_i | input | 1 | Pulse: the current frame is complete |
| frame_len_i | input | 4 | Total length in bytes of the ending frame (3 to 13) |
| cmd_wr_i | input | 1 | Host command write strobe |
| cmd_i | input | 5 | Command word; bit 2 releases, bit 3 clears overrun |
| msg_count_o | output | 7 | Number of stored messages |
| rx_full_o | output | 1 | 1 when at least one message is stored |
| overrun_o | output | 1 | Sticky flag: a message was lost for lack of space |
| miss_o | output | 1 | The current or last frame was destroyed by overflow |
| used_bytes_o | output | 7 | Bytes occupied by stored messages plus the frame in progress |

## Verification
For every frame length from 3 to 13, the store is filled until one message is refused. This shows whether the space check rounds at the exact capacity: the accepted count must equal 64 divided by the length. The store is then drained one release at a time, which separates FIFO-ordered freeing from freeing a fixed amount. A run with mixed lengths (3, 13, 7) shows whether each release subtracts the oldest length rather than the newest. Separate patterns cover these cases: a frame that writes past the capacity before it is refused; a frame aborted by reset mode; a release that lands in the same cycle as a store; a clear that lands in the same cycle as a drop; and commands with the strobe low or with only the inert bits set.

// File: rtl/rxmt_pkg.sv
package rxmt_pkg;

  // Command bit positions decoded by the host command path.
  localparam int CMD_W       = 5;
  localparam int CMD_REL_BIT = 2;
  localparam int CMD_CLR_BIT = 3;

  typedef struct packed {
    logic release_buf;
    logic clear_ovr;
  } host_cmd_t;

  function automatic host_cmd_t decode_cmd(input logic wr, input logic [CMD_W-1:0] word);
    host_cmd_t c;
    c.release_buf = wr & word[CMD_REL_BIT];
    c.clear_ovr   = wr & word[CMD_CLR_BIT];
    return c;
  endfunction

  // True when a whole message of len bytes fits beside held bytes.
  function automatic logic msg_fits(input int unsigned held, input int unsigned len,
                                    input int unsigned cap);
    return (held + len) <= cap;
  endfunction

  // True when one more byte of the frame in progress can be counted.
  function automatic logic byte_room(input int unsigned held, input int unsigned part,
                                     input int unsigned cap);
    return (held + part) < cap;
  endfunction

  // Next index of a circular pointer over depth slots.
  function automatic int unsigned ring_next(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/rxmt_len_queue.sv
module rxmt_len_queue #(
  parameter int DEPTH = 21,
  parameter int LEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [LEN_W-1:0] push_len_i,
  input  logic             pop_i,
  output logic [LEN_W-1:0] head_len_o
);
  import rxmt_pkg::*;

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [LEN_W-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;

  always_ff @(posedge clk_i) begin
    if (push_i) slot_q[wr_ptr_q] <= push_len_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (push_i) wr_ptr_q <= PTR_W'(ring_next(32'(wr_ptr_q), DEPTH));
      if (pop_i)  rd_ptr_q <= PTR_W'(ring_next(32'(rd_ptr_q), DEPTH));
    end
  end

  assign head_len_o = slot_q[rd_ptr_q];

endmodule

// File: rtl/rxmt_frame_track.sv
module rxmt_frame_track #(
  parameter int CAP_BYTES = 64,
  parameter int BYTE_W    = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              start_i,
  input  logic              byte_i,
  input  logic              end_i,
  input  logic [BYTE_W-1:0] committed_i,
  input  logic              drop_i,
  output logic              end_ev_o,
  output logic [BYTE_W-1:0] partial_o,
  output logic              miss_o
);
  import rxmt_pkg::*;

  logic              active_q;
  logic [BYTE_W-1:0] partial_q;
  logic              miss_q;
  logic              room;

  assign room     = byte_room(32'(committed_i), 32'(partial_q), CAP_BYTES);
  assign end_ev_o = end_i & active_q & ~abort_i & ~start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      partial_q <= '0;
      miss_q    <= 1'b0;
    end else if (abort_i) begin
      active_q  <= 1'b0;
      partial_q <= '0;
      miss_q    <= 1'b0;
    end else begin
      if (start_i) begin
        active_q  <= 1'b1;
        partial_q <= '0;
        miss_q    <= 1'b0;
      end else if (end_ev_o) begin
        active_q  <= 1'b0;
        partial_q <= '0;
      end else if (byte_i && active_q && room) begin
        partial_q <= partial_q + 1'b1;
      end
      if (drop_i) miss_q <= 1'b1;
    end
  end

  assign partial_o = partial_q;
  assign miss_o    = miss_q;

endmodule

// File: rtl/rxmt_store_acct.sv
module rxmt_store_acct #(
  parameter int CAP_BYTES = 64,
  parameter int BYTE_W    = 7,
  parameter int CNT_W     = 7,
  parameter int LEN_W     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              end_ev_i,
  input  logic [LEN_W-1:0]  frame_len_i,
  input  logic              rel_req_i,
  input  logic              clr_req_i,
  input  logic [LEN_W-1:0]  head_len_i,
  output logic              commit_ev_o,
  output logic              drop_ev_o,
  output logic              release_ev_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [BYTE_W-1:0] committed_o,
  output logic              overrun_o
);
  import rxmt_pkg::*;

  logic [CNT_W-1:0]  count_q;
  logic [BYTE_W-1:0] committed_q;
  logic              ovr_q;
  logic              fits;

  // Space is judged on the bytes held before any same-cycle release.
  assign fits         = msg_fits(32'(committed_q), 32'(frame_len_i), CAP_BYTES);
  assign commit_ev_o  = end_ev_i & fits;
  assign drop_ev_o    = end_ev_i & ~fits;
  assign release_ev_o = rel_req_i & (count_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q     <= '0;
      committed_q <= '0;
      ovr_q       <= 1'b0;
    end else begin
      count_q <= count_q + CNT_W'(commit_ev_o) - CNT_W'(release_ev_o);
      committed_q <= committed_q
                   + (commit_ev_o  ? BYTE_W'(frame_len_i) : '0)
                   - (release_ev_o ? BYTE_W'(head_len_i)  : '0);
      if (drop_ev_o)      ovr_q <= 1'b1;
      else if (clr_req_i) ovr_q <= 1'b0;
    end
  end

  assign count_o     = count_q;
  assign committed_o = committed_q;
  assign overrun_o   = ovr_q;

endmodule

// File: rtl/rx_msg_tracker.sv
module rx_msg_tracker #(
  parameter int CAP_BYTES = 64,
  parameter int MIN_LEN   = 3,
  parameter int MAX_LEN   = 13,
  parameter int CNT_W     = 7,
  parameter int BYTE_W    = $clog2(CAP_BYTES + 1),
  parameter int LEN_W     = $clog2(MAX_LEN + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     reset_mode_i,
  input  logic                     frame_start_i,
  input  logic                     byte_wr_i,
  input  logic                     frame_end_i,
  input  logic [LEN_W-1:0]         frame_len_i,
  input  logic                     cmd_wr_i,
  input  logic [rxmt_pkg::CMD_W-1:0] cmd_i,
  output logic [CNT_W-1:0]         msg_count_o,
  output logic                     rx_full_o,
  output logic                     overrun_o,
  output logic                     miss_o,
  output logic [BYTE_W-1:0]        used_bytes_o
);
  import rxmt_pkg::*;

  localparam int SLOTS = CAP_BYTES / MIN_LEN;

  host_cmd_t         hcmd;
  logic              end_ev, commit_ev, drop_ev, release_ev;
  logic [BYTE_W-1:0] committed, partial;
  logic [LEN_W-1:0]  head_len;

  assign hcmd = decode_cmd(cmd_wr_i, cmd_i);

  rxmt_frame_track #(.CAP_BYTES(CAP_BYTES), .BYTE_W(BYTE_W)) frame_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .abort_i    (reset_mode_i),
    .start_i    (frame_start_i),
    .byte_i     (byte_wr_i),
    .end_i      (frame_end_i),
    .committed_i(committed),
    .drop_i     (drop_ev),
    .end_ev_o   (end_ev),
    .partial_o  (partial),
    .miss_o     (miss_o)
  );

  rxmt_store_acct #(.CAP_BYTES(CAP_BYTES), .BYTE_W(BYTE_W), .CNT_W(CNT_W),
                    .LEN_W(LEN_W)) acct_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .end_ev_i    (end_ev),
    .frame_len_i (frame_len_i),
    .rel_req_i   (hcmd.release_buf),
    .clr_req_i   (hcmd.clear_ovr),
    .head_len_i  (head_len),
    .commit_ev_o (commit_ev),
    .drop_ev_o   (drop_ev),
    .release_ev_o(release_ev),
    .count_o     (msg_count_o),
    .committed_o (committed),
    .overrun_o   (overrun_o)
  );

  rxmt_len_queue #(.DEPTH(SLOTS), .LEN_W(LEN_W)) lenq_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (commit_ev),
    .push_len_i(frame_len_i),
    .pop_i     (release_ev),
    .head_len_o(head_len)
  );

  assign rx_full_o    = (msg_count_o != '0);
  assign used_bytes_o = committed + partial;

endmodule

// File: rtl/rx_msg_tracker_chk.sv
module rx_msg_tracker_chk #(
  parameter int CAP_BYTES = 64,
  parameter int SLOTS     = 21,
  parameter int CNT_W     = 7,
  parameter int BYTE_W    = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reset_mode,
  input logic              rel_cmd,
  input logic              clr_cmd,
  input logic              commit_ev,
  input logic              drop_ev,
  input logic              release_ev,
  input logic [CNT_W-1:0]  count,
  input logic [BYTE_W-1:0] used,
  input logic [BYTE_W-1:0] committed,
  input logic              full,
  input logic              overrun,
  input logic              miss
);
  AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ev && !release_ev |=> count == $past(count) + 1'b1); // R1
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    release_ev && !commit_ev |=> count == $past(count) - 1'b1); // R1
  AST_FULL_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ev |=> full); // R2
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev && !release_ev |=> overrun && miss && count == $past(count)); // R3
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !clr_cmd |=> overrun); // R4
  AST_ABORT_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    reset_mode |=> used == committed && !miss); // R6
  AST_REL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rel_cmd && count == '0 && !commit_ev |=> count == '0); // R7
  AST_USED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    used <= BYTE_W'(CAP_BYTES) && count <= CNT_W'(SLOTS)); // R8
endmodule

bind rx_msg_tracker rx_msg_tracker_chk #(
  .CAP_BYTES(CAP_BYTES), .SLOTS(SLOTS), .CNT_W(CNT_W), .BYTE_W(BYTE_W)
) chk_i (
  .clk       (clk_i),
  .rst_n     (rst_ni),
  .reset_mode(reset_mode_i),
  .rel_cmd   (hcmd.release_buf),
  .clr_cmd   (hcmd.clear_ovr),
  .commit_ev (commit_ev),
  .drop_ev   (drop_ev),
  .release_ev(release_ev),
  .count     (msg_count_o),
  .used      (used_bytes_o),
  .committed (committed),
  .full      (rx_full_o),
  .overrun   (overrun_o),
  .miss      (miss_o)
);

// File: tb/rx_msg_tracker_tb.sv
module rx_msg_tracker_tb_top;
  localparam int CAP = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reset_mode = 1'b0;
  logic       f_start = 1'b0, f_byte = 1'b0, f_end = 1'b0;
  logic [3:0] f_len = '0;
  logic       cmd_wr = 1'b0;
  logic [4:0] cmd = '0;
  logic [6:0] count, used;
  logic       full, ovr, miss;

  int checks = 0, errors = 0;
  bit done = 0;

  // Reference model state
  int m_q[32];
  int m_hd = 0, m_tl = 0, m_count = 0, m_committed = 0, m_partial = 0;
  bit m_active = 0, m_ovr = 0, m_miss = 0;

  always #10 clk = ~clk;

  rx_msg_tracker dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reset_mode_i(reset_mode),
    .frame_start_i(f_start), .byte_wr_i(f_byte), .frame_end_i(f_end),
    .frame_len_i(f_len), .cmd_wr_i(cmd_wr), .cmd_i(cmd),
    .msg_count_o(count), .rx_full_o(full), .overrun_o(ovr), .miss_o(miss),
    .used_bytes_o(used)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R1 count", int'(count), m_count);
    chk("R2 status", int'(full), (m_count != 0) ? 1 : 0);
    chk("R4 overrun", int'(ovr), int'(m_ovr));
    chk("R5 miss", int'(miss), int'(m_miss));
    chk("R8 used", int'(used), m_committed + m_partial);
  endtask

  // One clock with the given strobes; the model follows the requirements.
  task automatic drive(bit s, bit b, bit e, int len, bit wr, logic [4:0] c);
    bit end_ok, rel, clr, drop;
    int hl;
    f_start = s; f_byte = b; f_end = e; f_len = 4'(len); cmd_wr = wr; cmd = c;
    @(posedge clk);
    @(negedge clk);
    f_start = 0; f_byte = 0; f_end = 0; cmd_wr = 0; cmd = '0;
    end_ok = e && m_active && !reset_mode && !s;
    rel = wr && c[2] && (m_count > 0);
    clr = wr && c[3];
    hl = m_q[m_hd];
    drop = 0;
    if (reset_mode) begin
      m_active = 0; m_partial = 0; m_miss = 0;
    end else if (s) begin
      m_active = 1; m_partial = 0; m_miss = 0;
    end else if (end_ok) begin
      m_active = 0; m_partial = 0;
      if (m_committed + len <= CAP) begin
        m_q[m_tl] = len; m_tl = (m_tl + 1) % 32;
        m_count++; m_committed += len;
      end else begin
        drop = 1; m_miss = 1;
      end
    end else if (b && m_active && (m_committed + m_partial < CAP)) begin
      m_partial++;
    end
    if (rel) begin
      m_hd = (m_hd + 1) % 32; m_count--; m_committed -= hl;
    end
    if (drop) m_ovr = 1;
    else if (clr) m_ovr = 0;
  endtask

  task automatic frame(int len, int nbytes);
    drive(1, 0, 0, 0, 0, '0);
    for (int i = 0; i < nbytes; i++) drive(0, 1, 0, 0, 0, '0);
    drive(0, 0, 1, len, 0, '0);
    check_all();
  endtask

  task automatic release_one();
    drive(0, 0, 0, 0, 1, 5'b00100);
    check_all();
  endtask

  task automatic drain();
    while (m_count > 0) release_one();
    drive(0, 0, 0, 0, 1, 5'b01000);
    check_all();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk("R10 count", int'(count), 0);
    chk("R10 used", int'(used), 0);
    chk("R10 flags", int'({full, ovr, miss}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: release on empty store
    release_one();

    // Sweep every legal length: fill to the first refusal, then drain (R1, R3, R7)
    for (int len = 3; len <= 13; len++) begin
      for (int k = 0; k <= CAP / len; k++) frame(len, len);
      chk("R1 fill", int'(count), CAP / len);
      chk("R3 overrun", int'(ovr), 1);
      chk("R3 miss", int'(miss), 1);
      chk("R3 used", int'(used), (CAP / len) * len);
      for (int k = 0; k < CAP / len; k++) begin
        release_one();
        chk("R7 release step", int'(used), (CAP / len - k - 1) * len);
      end
      release_one();
      chk("R7 empty", int'(count), 0);
      // R9: inert bits and a strobe-less clear leave overrun set
      drive(0, 0, 0, 0, 1, 5'b10011);
      drive(0, 0, 0, 0, 0, 5'b01100);
      chk("R9 ignored", int'(ovr), 1);
      drive(0, 0, 0, 0, 1, 5'b01000);
      chk("R4 clear", int'(ovr), 0);
      check_all();
    end

    // R7: FIFO release order with mixed lengths
    frame(3, 3); frame(13, 13); frame(7, 7);
    chk("R7 mixed", int'(used), 23);
    release_one(); chk("R7 oldest first", int'(used), 20);
    release_one(); chk("R7 second", int'(used), 7);
    release_one(); chk("R7 third", int'(used), 0);
    chk("R5 miss stays low", int'(miss), 0);

    // R8 / R3: byte writes past capacity are not counted, drop frees them
    for (int k = 0; k < 9; k++) frame(7, 7);
    drive(1, 0, 0, 0, 0, '0);
    for (int i = 0; i < 5; i++) drive(0, 1, 0, 0, 0, '0);
    chk("R8 saturate", int'(used), 64);
    // R4: drop and clear in the same cycle keep overrun set
    drive(0, 0, 1, 5, 1, 5'b01000);
    check_all();
    chk("R4 set wins", int'(ovr), 1);
    chk("R3 freed", int'(used), 63);
    // R5: next accepted start clears miss
    drive(1, 0, 0, 0, 0, '0);
    chk("R5 start clears", int'(miss), 0);
    drive(0, 0, 1, 9, 0, '0);
    drain();

    // R1: store and release in the same cycle
    frame(4, 4);
    drive(1, 0, 0, 0, 0, '0);
    for (int i = 0; i < 6; i++) drive(0, 1, 0, 0, 0, '0);
    drive(0, 0, 1, 6, 1, 5'b00100);
    check_all();
    chk("R1 same cycle", int'(count), 1);
    chk("R7 same cycle used", int'(used), 6);
    drain();

    // R6: reset mode aborts a frame and ignores strobes
    frame(5, 5);
    drive(1, 0, 0, 0, 0, '0);
    for (int i = 0; i < 4; i++) drive(0, 1, 0, 0, 0, '0);
    chk("R8 partial", int'(used), 9);
    reset_mode = 1'b1;
    drive(0, 1, 0, 0, 0, '0);
    chk("R6 abort frees", int'(used), 5);
    drive(1, 0, 0, 0, 0, '0);
    drive(0, 0, 1, 4, 0, '0);
    chk("R6 end ignored", int'(count), 1);
    check_all();
    reset_mode = 1'b0;
    drive(0, 0, 1, 4, 0, '0);
    chk("R6 no frame after abort", int'(count), 1);
    drain();
    check_all();

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule